// File: doc/BRIEF.md
# NAND Status and Protection Registers

This block holds the three 8-bit control and status registers of a serial NAND device: a protection register, a configuration register and a status register. The command decoder reaches them through a register select, a write strobe with write data, and a combinational read port. From the register contents it produces decoded controls for the rest of the device: the protected block range, the ECC enable, the read mode (buffer or continuous) and OTP access.

The array engine reports events through single-cycle pulses and level inputs. These cover the start of a program or erase, a program or erase failure, an ECC result, the busy state and the state of the remap table. The block turns these into sticky status bits, each with its own clearing rule. Two lock bits in the configuration register can be set but never cleared. One of them freezes the protection register. A synchronizer inside the block releases the asynchronous reset in step with the clock.

Top module: `nand_status_regs`

## Requirements
- R1: After reset the protection register reads 0x7C (BP bits and top/bottom select set), the configuration register reads 0x10 (ECC enable set, buffer-mode bit equal to parameter BUF_RST, which defaults to 0), and the status register reads 0x00.
- R2: rd_data shows the register picked by reg_sel: 0 protection, 1 configuration, 2 status, 3 gives 0x00. Configuration bits 2..0 and status bit 7 always read 0. Reads are served while busy is set.
- R3: A write with wr_en is visible one cycle later. A write to any register is ignored while status bit 0 (busy) is 1.
- R4: A write with reg_sel=2 changes no status bit.
- R5: Configuration bit 7 (OTP lock) and bit 5 (protection lock) stay 1 once set, and writing 0 to them does not clear them.
- R6: While configuration bit 5 is 1, writes to the protection register are ignored.
- R7: With BP=prot[6:3] and TB=prot[2]: BP=0 gives prot_en=0 with prot_lo=prot_hi=0. BP3=1 together with BP2 or BP1 gives prot_all=1 and the range 0..NUM_BLOCKS-1. In every other case cnt=min(NUM_BLOCKS, BLK_UNIT<<(BP-1)), and TB=1 selects 0..cnt-1 while TB=0 selects NUM_BLOCKS-cnt..NUM_BLOCKS-1. In these other cases prot_all=0.
- R8: otp_access=cfg[6], ecc_en=cfg[4], buf_mode=cfg[3], and otp_locked=cfg[7].
- R9: op_start clears program fail (status bit 3) and erase fail (bit 2). A prog_fail or erase_fail pulse sets its bit and wins over op_start in the same cycle. Otherwise both bits hold.
- R10: Status bits 5..4 take ecc_code when ecc_valid is high (00 clean, 01 corrected, 10 uncorrectable, 11 several uncorrectable pages). Only reset clears them.
- R11: The write-enable latch (status bit 1) is set by wen_cmd and cleared by wdis_cmd, op_start or remap_done. A clear wins over a set in the same cycle.
- R12: Status bit 0 follows busy_in and status bit 6 follows tbl_full_in, each one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Selected register contents |
| op_start | input | 1 | Program or erase starts (pulse) |
| prog_fail | input | 1 | Program failed (pulse) |
| erase_fail | input | 1 | Erase failed (pulse) |
| ecc_valid | input | 1 | ECC result valid (pulse) |
| ecc_code | input | 2 | ECC result code |
| busy_in | input | 1 | Array engine busy level |
| tbl_full_in | input | 1 | Remap table full level |
| wen_cmd | input | 1 | Write-enable command (pulse) |
| wdis_cmd | input | 1 | Write-disable command (pulse) |
| remap_done | input | 1 | Remap command done (pulse) |
| prot_en | output | 1 | Some blocks are protected |
| prot_all | output | 1 | Whole array protected, TB ignored |
| prot_lo | output | log2(NUM_BLOCKS) | First protected block |
| prot_hi | output | log2(NUM_BLOCKS) | Last protected block |
| ecc_en | output | 1 | ECC enabled |
| buf_mode | output | 1 | Buffer read mode selected |
| otp_access | output | 1 | OTP area access enabled |
| otp_locked | output | 1 | OTP lock set |
| wel | output | 1 | Write-enable latch |

## Verification
The bench builds the block with NUM_BLOCKS=64, BLK_UNIT=1 and BUF_RST=0. With only 64 blocks, BP=7 doubles exactly up to the full array, and BP=8 and BP=9 ask for more blocks than exist. This exercises the cap on the count, which the default 1024-block size never reaches. The small array also keeps the upper-end ranges short enough to check exactly at both TB settings.

// File: rtl/nsr_pkg.sv
package nsr_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SEL_PROT = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // protection register layout
  localparam int P_BP_HI = 6;
  localparam int P_BP_LO = 3;
  localparam int P_TB    = 2;
  localparam logic [REG_W-1:0] PROT_RST = 8'h7C;

  // configuration register layout
  localparam int C_OTPL  = 7;
  localparam int C_OTPE  = 6;
  localparam int C_PLOCK = 5;
  localparam int C_ECCE  = 4;
  localparam int C_BUF   = 3;

  // status register layout
  localparam int S_FULL  = 6;
  localparam int S_ECC1  = 5;
  localparam int S_ECC0  = 4;
  localparam int S_PFAIL = 3;
  localparam int S_EFAIL = 2;
  localparam int S_WEL   = 1;
  localparam int S_BUSY  = 0;
endpackage

// File: rtl/nsr_rst_sync.sv
module nsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/nsr_prot.sv
module nsr_prot
  import nsr_pkg::*;
#(
  parameter int NUM_BLOCKS = 1024,
  parameter int BLK_UNIT   = 1,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int CNT_W     = BLK_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             busy_i,
  input  logic             lock_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o,
  output logic             prot_en_o,
  output logic             prot_all_o,
  output logic [BLK_W-1:0] prot_lo_o,
  output logic [BLK_W-1:0] prot_hi_o
);
  logic [REG_W-1:0] q_q, q_d;
  logic             ld_en;

  // write gate: busy and the lock both block the update
  assign ld_en = wr_i && !busy_i && !lock_i;

  always_comb begin
    q_d = q_q;
    if (ld_en) q_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= PROT_RST;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // range decode
  logic [3:0]       bp;
  logic             tb, none_c, all_c;
  logic [3:0]       shamt;
  logic [31:0]      raw;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    bp     = q_q[P_BP_HI:P_BP_LO];
    tb     = q_q[P_TB];
    none_c = (bp == 4'd0);
    all_c  = bp[3] & (bp[2] | bp[1]);
    shamt  = bp - 4'd1;
    raw    = 32'(BLK_UNIT) << shamt;
    cnt    = (raw > 32'(NUM_BLOCKS)) ? CNT_W'(NUM_BLOCKS) : raw[CNT_W-1:0];

    prot_en_o  = 1'b0;
    prot_all_o = 1'b0;
    prot_lo_o  = '0;
    prot_hi_o  = '0;
    if (all_c) begin
      prot_en_o  = 1'b1;
      prot_all_o = 1'b1;
      prot_hi_o  = BLK_W'(NUM_BLOCKS - 1);
    end else if (!none_c) begin
      prot_en_o = 1'b1;
      if (tb) begin
        prot_lo_o = '0;
        prot_hi_o = BLK_W'(cnt - CNT_W'(1));
      end else begin
        prot_lo_o = BLK_W'(CNT_W'(NUM_BLOCKS) - cnt);
        prot_hi_o = BLK_W'(NUM_BLOCKS - 1);
      end
    end
  end

  assert_prot_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> $stable(q_q));
  assert_range_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prot_en_o |-> (prot_lo_o <= prot_hi_o));
  assert_busy_blocks_prot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(q_q));
endmodule

// File: rtl/nsr_cfg.sv
module nsr_cfg
  import nsr_pkg::*;
#(
  parameter bit BUF_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             busy_i,
  input  logic [4:0]       wdata_i,  // register bits 7..3
  output logic [REG_W-1:0] q_o
);
  localparam logic [REG_W-1:0] CFG_RST = (REG_W'(1) << C_ECCE) | (REG_W'(BUF_RST) << C_BUF);

  logic [REG_W-1:0] q_q, q_d;
  logic             ld_en;

  assign ld_en = wr_i && !busy_i;

  always_comb begin
    q_d = q_q;
    if (ld_en) begin
      q_d[C_OTPL]  = q_q[C_OTPL]  | wdata_i[4];  // set-only
      q_d[C_OTPE]  = wdata_i[3];
      q_d[C_PLOCK] = q_q[C_PLOCK] | wdata_i[2];  // set-only
      q_d[C_ECCE]  = wdata_i[1];
      q_d[C_BUF]   = wdata_i[0];
    end
    q_d[2:0] = 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= CFG_RST;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  assert_otp_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    q_q[C_OTPL] |=> q_q[C_OTPL]);
  assert_prot_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    q_q[C_PLOCK] |=> q_q[C_PLOCK]);
  assert_busy_blocks_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(q_q));
endmodule

// File: rtl/nsr_stat.sv
module nsr_stat
  import nsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_start_i,
  input  logic             prog_fail_i,
  input  logic             erase_fail_i,
  input  logic             ecc_valid_i,
  input  logic [1:0]       ecc_code_i,
  input  logic             busy_in_i,
  input  logic             full_in_i,
  input  logic             wen_i,
  input  logic             wdis_i,
  input  logic             remap_i,
  output logic [REG_W-1:0] q_o
);
  logic       pfail_q, pfail_d;
  logic       efail_q, efail_d;
  logic [1:0] ecc_q, ecc_d;
  logic       wel_q, wel_d;
  logic       busy_q, full_q;

  always_comb begin
    pfail_d = pfail_q;
    efail_d = efail_q;
    if (op_start_i) begin
      pfail_d = 1'b0;
      efail_d = 1'b0;
    end
    if (prog_fail_i)  pfail_d = 1'b1;
    if (erase_fail_i) efail_d = 1'b1;

    ecc_d = ecc_q;
    if (ecc_valid_i) ecc_d = ecc_code_i;

    wel_d = wel_q;
    if (wen_i) wel_d = 1'b1;
    if (wdis_i || op_start_i || remap_i) wel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfail_q <= 1'b0;
      efail_q <= 1'b0;
      ecc_q   <= 2'b00;
      wel_q   <= 1'b0;
      busy_q  <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      pfail_q <= pfail_d;
      efail_q <= efail_d;
      ecc_q   <= ecc_d;
      wel_q   <= wel_d;
      busy_q  <= busy_in_i;
      full_q  <= full_in_i;
    end
  end

  always_comb begin
    q_o          = '0;
    q_o[S_FULL]  = full_q;
    q_o[S_ECC1]  = ecc_q[1];
    q_o[S_ECC0]  = ecc_q[0];
    q_o[S_PFAIL] = pfail_q;
    q_o[S_EFAIL] = efail_q;
    q_o[S_WEL]   = wel_q;
    q_o[S_BUSY]  = busy_q;
  end

  assert_ecc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ecc_valid_i |=> $stable(ecc_q));
  assert_pfail_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start_i && !prog_fail_i) |=> !pfail_q);
  assert_efail_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fail_i |=> efail_q);
  assert_wel_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wdis_i || remap_i) |=> !wel_q);
  assert_busy_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_in_i |=> q_o[S_BUSY]);
endmodule

// File: rtl/nand_status_regs.sv
module nand_status_regs
  import nsr_pkg::*;
#(
  parameter int NUM_BLOCKS = 1024,
  parameter int BLK_UNIT   = 1,
  parameter bit BUF_RST    = 1'b0,
  localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_sel,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic             op_start,
  input  logic             prog_fail,
  input  logic             erase_fail,
  input  logic             ecc_valid,
  input  logic [1:0]       ecc_code,
  input  logic             busy_in,
  input  logic             tbl_full_in,
  input  logic             wen_cmd,
  input  logic             wdis_cmd,
  input  logic             remap_done,
  output logic             prot_en,
  output logic             prot_all,
  output logic [BLK_W-1:0] prot_lo,
  output logic [BLK_W-1:0] prot_hi,
  output logic             ecc_en,
  output logic             buf_mode,
  output logic             otp_access,
  output logic             otp_locked,
  output logic             wel
);
  logic             rst_ns;
  logic [REG_W-1:0] prot_q, cfg_q, stat_q;
  logic             busy_bit;
  reg_sel_e         sel;

  assign sel      = reg_sel_e'(reg_sel);
  assign busy_bit = stat_q[S_BUSY];

  nsr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  nsr_prot #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_UNIT(BLK_UNIT)) u_prot (
    .clk        (clk),
    .rst_n      (rst_ns),
    .wr_i       (wr_en && (sel == SEL_PROT)),
    .busy_i     (busy_bit),
    .lock_i     (cfg_q[C_PLOCK]),
    .wdata_i    (wr_data),
    .q_o        (prot_q),
    .prot_en_o  (prot_en),
    .prot_all_o (prot_all),
    .prot_lo_o  (prot_lo),
    .prot_hi_o  (prot_hi)
  );

  nsr_cfg #(.BUF_RST(BUF_RST)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_ns),
    .wr_i    (wr_en && (sel == SEL_CFG)),
    .busy_i  (busy_bit),
    .wdata_i (wr_data[7:3]),
    .q_o     (cfg_q)
  );

  nsr_stat u_stat (
    .clk          (clk),
    .rst_n        (rst_ns),
    .op_start_i   (op_start),
    .prog_fail_i  (prog_fail),
    .erase_fail_i (erase_fail),
    .ecc_valid_i  (ecc_valid),
    .ecc_code_i   (ecc_code),
    .busy_in_i    (busy_in),
    .full_in_i    (tbl_full_in),
    .wen_i        (wen_cmd),
    .wdis_i       (wdis_cmd),
    .remap_i      (remap_done),
    .q_o          (stat_q)
  );

  always_comb begin
    case (sel)
      SEL_PROT: rd_data = prot_q;
      SEL_CFG:  rd_data = cfg_q;
      SEL_STAT: rd_data = stat_q;
      default:  rd_data = '0;
    endcase
  end

  assign ecc_en     = cfg_q[C_ECCE];
  assign buf_mode   = cfg_q[C_BUF];
  assign otp_access = cfg_q[C_OTPE];
  assign otp_locked = cfg_q[C_OTPL];
  assign wel        = stat_q[S_WEL];

  assert_none_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (sel == SEL_NONE) |-> (rd_data == 8'h00));
endmodule

// File: tb/test_nand_status_regs.sv
module test_nand_status_regs;
  localparam int NB = 64;
  localparam int BW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    reg_sel;
  logic          wr_en;
  logic [7:0]    wr_data, rd_data;
  logic          op_start, prog_fail, erase_fail, ecc_valid;
  logic [1:0]    ecc_code;
  logic          busy_in, tbl_full_in, wen_cmd, wdis_cmd, remap_done;
  logic          prot_en, prot_all, ecc_en, buf_mode, otp_access, otp_locked, wel;
  logic [BW-1:0] prot_lo, prot_hi;

  always #2 clk = ~clk;

  nand_status_regs #(.NUM_BLOCKS(NB), .BLK_UNIT(1), .BUF_RST(1'b0)) i_nand_status_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .op_start(op_start), .prog_fail(prog_fail),
    .erase_fail(erase_fail), .ecc_valid(ecc_valid), .ecc_code(ecc_code),
    .busy_in(busy_in), .tbl_full_in(tbl_full_in), .wen_cmd(wen_cmd),
    .wdis_cmd(wdis_cmd), .remap_done(remap_done), .prot_en(prot_en),
    .prot_all(prot_all), .prot_lo(prot_lo), .prot_hi(prot_hi), .ecc_en(ecc_en),
    .buf_mode(buf_mode), .otp_access(otp_access), .otp_locked(otp_locked), .wel(wel)
  );

  typedef struct {
    int          kind;   // 0..3 register read, 4 range decode, 5 config flags
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [31:0] pk(bit en, bit all, int lo, int hi);
    return {18'd0, en, all, 6'(lo), 6'(hi)};
  endfunction

  // monitor: compares one expected item per falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      if (it.kind < 4)       act = {24'd0, rd_data};
      else if (it.kind == 4) act = {18'd0, prot_en, prot_all, prot_lo, prot_hi};
      else                   act = {28'd0, otp_access, ecc_en, buf_mode, otp_locked};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_item(int kind, logic [31:0] exp, string req);
    item_t it;
    @(posedge clk); #1;
    if (kind < 4) reg_sel = 2'(kind);
    it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic wr(int sel, logic [7:0] d);
    @(posedge clk); #1;
    reg_sel = 2'(sel); wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle_all();
    wr_en = 0; op_start = 0; prog_fail = 0; erase_fail = 0; ecc_valid = 0;
    wen_cmd = 0; wdis_cmd = 0; remap_done = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  // one-cycle pulse of a chosen set of event inputs
  task automatic pulse(bit st, bit pf, bit ef, bit ev, logic [1:0] ec, bit we, bit wd, bit rm);
    @(posedge clk); #1;
    op_start = st; prog_fail = pf; erase_fail = ef; ecc_valid = ev; ecc_code = ec;
    wen_cmd = we; wdis_cmd = wd; remap_done = rm;
    @(posedge clk); #1;
    idle_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    reg_sel = 0; wr_data = 0; ecc_code = 0; busy_in = 0; tbl_full_in = 0;
    idle_all();
    do_reset();

    // R1 reset state
    expect_item(0, 32'h7C, "R1 prot reset");
    expect_item(1, 32'h10, "R1 cfg reset");
    expect_item(2, 32'h00, "R1 status reset");
    expect_item(4, pk(1, 1, 0, NB-1), "R7 reset all protected");
    expect_item(5, 32'h4, "R8 reset cfg flags");
    expect_item(3, 32'h00, "R2 unused select");

    // R2/R3/R8 config write, reserved bits masked
    wr(1, 8'h4F);
    expect_item(1, 32'h48, "R2 R3 cfg write reserved masked");
    expect_item(5, 32'hA, "R8 cfg flags");

    // R4 status write ignored
    wr(2, 8'hFF);
    expect_item(2, 32'h00, "R4 status write ignored");

    // R7 decode cases
    wr(0, 8'h0C);
    expect_item(0, 32'h0C, "R3 prot write");
    expect_item(4, pk(1, 0, 0, 0), "R7 BP1 lower");
    wr(0, 8'h18);
    expect_item(4, pk(1, 0, NB-4, NB-1), "R7 BP3 upper");
    wr(0, 8'h44);
    expect_item(4, pk(1, 0, 0, NB-1), "R7 BP8 capped lower");
    wr(0, 8'h04);
    expect_item(4, pk(0, 0, 0, 0), "R7 BP0 none");
    wr(0, 8'h50);
    expect_item(4, pk(1, 1, 0, NB-1), "R7 BP10 all TB ignored");
    wr(0, 8'h38);
    expect_item(4, pk(1, 0, 0, NB-1), "R7 BP7 upper exact");

    // R11 write-enable latch
    pulse(0, 0, 0, 0, 2'b00, 1, 0, 0);
    expect_item(2, 32'h02, "R11 wel set");
    pulse(0, 0, 0, 0, 2'b00, 0, 1, 0);
    expect_item(2, 32'h00, "R11 wel cleared by disable");
    pulse(0, 0, 0, 0, 2'b00, 1, 1, 0);
    expect_item(2, 32'h00, "R11 clear wins");
    pulse(0, 0, 0, 0, 2'b00, 1, 0, 0);
    pulse(0, 0, 0, 0, 2'b00, 0, 0, 1);
    expect_item(2, 32'h00, "R11 cleared by remap");
    pulse(0, 0, 0, 0, 2'b00, 1, 0, 0);
    pulse(1, 0, 0, 0, 2'b00, 0, 0, 0);
    expect_item(2, 32'h00, "R11 cleared by op start");

    // R9 fail flags
    pulse(0, 1, 0, 0, 2'b00, 0, 0, 0);
    expect_item(2, 32'h08, "R9 program fail set");
    pulse(0, 0, 1, 0, 2'b00, 0, 0, 0);
    expect_item(2, 32'h0C, "R9 erase fail set, pfail holds");
    pulse(1, 0, 0, 0, 2'b00, 0, 0, 0);
    expect_item(2, 32'h00, "R9 cleared at start");
    pulse(1, 0, 1, 0, 2'b00, 0, 0, 0);
    expect_item(2, 32'h04, "R9 fail wins over start");
    pulse(1, 0, 0, 0, 2'b00, 0, 0, 0);

    // R10 ECC bits
    pulse(0, 0, 0, 1, 2'b01, 0, 0, 0);
    expect_item(2, 32'h10, "R10 corrected");
    pulse(1, 0, 0, 0, 2'b00, 0, 0, 0);
    expect_item(2, 32'h10, "R10 kept across op start");
    pulse(0, 0, 0, 1, 2'b10, 0, 0, 0);
    expect_item(2, 32'h20, "R10 uncorrectable");
    pulse(0, 0, 0, 1, 2'b11, 0, 0, 0);
    wr(2, 8'h00);
    expect_item(2, 32'h30, "R10 R4 multi, write ignored");

    // R12 busy and full, R3 write blocked while busy, R2 read while busy
    @(posedge clk); #1 busy_in = 1'b1;
    expect_item(2, 32'h31, "R12 busy follows");
    @(posedge clk); #1 tbl_full_in = 1'b1;
    expect_item(2, 32'h71, "R12 full follows");
    wr(1, 8'h00);
    wr(0, 8'h7C);
    expect_item(1, 32'h48, "R3 R2 cfg write ignored while busy");
    expect_item(0, 32'h38, "R3 prot write ignored while busy");
    @(posedge clk); #1 busy_in = 1'b0; tbl_full_in = 1'b0;
    expect_item(2, 32'h30, "R12 busy and full drop");

    // R5/R6 locks
    wr(1, 8'h68);
    expect_item(1, 32'h68, "R5 protection lock set");
    wr(0, 8'h7C);
    expect_item(0, 32'h38, "R6 prot write ignored when locked");
    wr(1, 8'h00);
    expect_item(1, 32'h20, "R5 protection lock sticky");
    wr(1, 8'h80);
    expect_item(1, 32'hA0, "R5 otp lock set");
    wr(1, 8'h00);
    expect_item(1, 32'hA0, "R5 otp lock sticky");
    expect_item(5, 32'h1, "R8 otp locked flag");

    // R10 R1 reset clears ECC and locks
    do_reset();
    expect_item(2, 32'h00, "R10 R1 reset clears ecc");
    expect_item(1, 32'h10, "R1 cfg after reset");

    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule